// File: doc/BRIEF.md
# Four-Slot Out-of-Order Issue Window

This block sits between instruction fetch and a set of execution pipelines. It holds up to four decoded instructions. Each carries a class (arithmetic, load or store), an optional destination register, up to two optional source registers, and an age tag that the block assigns in program order. In every cycle it selects each slot whose hazards are clear and sends all of them down the pipes together. Issue width has no limit other than the window size, and a younger instruction may overtake an older one that is stalled. In the same cycle it takes exactly as many new instructions from the fetch stream as the free slots allow, so the refill count follows the issue count.

Results are forwarded. A consumer of an arithmetic result may issue in the cycle after its producer. A consumer of a load result must wait one cycle more, because of the memory stage. No renaming is done, so an instruction waits while an older unissued instruction reads or writes its destination register. The block does not model execution units, register values or memory data. It reports per slot what issued, with the age tag and the issue cycle, and it gives a count of instructions reaching retirement, based on a fixed issue-to-retire latency for each class.

Top module: `ooo_issue_window`

## Requirements
- R1: While reset is held, and in the first cycle after it, no slot issues and `retire_cnt` is 0. In that first cycle the window is empty and `fetch_take` equals the smaller of `fetch_avail` and 4.
- R2: In every cycle `fetch_take` equals the smaller of `fetch_avail` and (empty slots + slots issuing that cycle). Taken instructions are the lowest-indexed fetch lanes. They become eligible to issue in the next cycle.
- R3: An occupied slot with no hazard issues in the cycle after it entered the window, even when an older slot is stalled.
- R4: A slot reading a register written by an older arithmetic instruction issues no earlier than one cycle after that producer issues, and issues exactly then if nothing else blocks it.
- R5: A slot reading a register written by a load issues no earlier than two cycles after the load issues, and issues exactly then if nothing else blocks it.
- R6: A slot with a destination does not issue while an older unissued slot reads or writes that same register.
- R7: Memory instructions (class 1 = load, class 2 or 3 = store) issue in program order. At most one memory instruction issues per cycle.
- R8: `issue_vld[i]` marks slot i issuing, with slot 0 the oldest. `issue_age` lane i carries that slot's age tag, which is the fetch sequence number modulo 2^AGE_W and starts at 0 after reset. `issue_cycle` counts cycles since reset, with the first cycle after reset numbered 0.
- R9: `retire_cnt` equals the number of arithmetic and store instructions issued 4 cycles earlier plus the number of loads issued 5 cycles earlier.
- R10: Any number of slots, up to all four, may issue in the same cycle.

Instruction word (20 bits, default parameters), lowest bit first: bits 4:0 source B, bit 5 source B valid, bits 10:6 source A, bit 11 source A valid, bits 16:12 destination, bit 17 destination valid, bits 19:18 class (0 arithmetic, 1 load, 2 or 3 store). Fetch lane i occupies `fetch_ins[20*i +: 20]`, and lane 0 is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_avail | input | 3 | Number of valid fetch lanes (0 to 4) |
| fetch_ins | input | 80 | Four instruction words, lane 0 oldest |
| fetch_take | output | 3 | Number of lanes accepted at the coming edge |
| issue_vld | output | 4 | Per-slot issue strobe, slot 0 oldest |
| issue_age | output | 32 | Per-slot age tag, 8 bits per lane |
| issue_cycle | output | 16 | Cycle number since reset |
| retire_cnt | output | 4 | Instructions reaching retirement this cycle |

## Verification
The stream opens with four mutually independent arithmetic instructions. This separates a window that issues all four at once from one with a hidden width limit, and it shows whether the refill reloads all four slots. Short directed groups follow, one for each hazard: an arithmetic chain, a load followed by its user, a write-after-read pair, a write-after-write pair, and a load-store-load run. Each group has an exact expected issue cycle, so an off-by-one in forwarding latency, a missing ordering rule or an over-strict rule shows up as a shifted cycle. A two-iteration histogram-update loop closes the stream and mixes all hazards at once. A cycle-level reference model predicts its issue order, refill counts and retirement counts.

// File: rtl/ooo_issue_window.sv
`timescale 1ns/1ps
module ooo_issue_window #(
  parameter int SLOTS = 4,
  parameter int NREG = 32,
  parameter int AGE_W = 8,
  parameter int CYC_W = 16,
  parameter int ALU_LAT = 4,
  parameter int LD_LAT = 5,
  localparam int REG_W = $clog2(NREG),
  localparam int INS_W = 3 * REG_W + 5,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int RET_W = $clog2(2 * SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       fetch_avail,
  input  logic [SLOTS*INS_W-1:0] fetch_ins,
  output logic [CNT_W-1:0]       fetch_take,
  output logic [SLOTS-1:0]       issue_vld,
  output logic [SLOTS*AGE_W-1:0] issue_age,
  output logic [CYC_W-1:0]       issue_cycle,
  output logic [RET_W-1:0]       retire_cnt
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  function automatic logic [REG_W-1:0] fld(input logic [INS_W-1:0] x, input int k);
    return x[k*(REG_W+1) +: REG_W];
  endfunction

  function automatic logic fv(input logic [INS_W-1:0] x, input int k);
    return x[k*(REG_W+1) + REG_W];
  endfunction

  function automatic logic reads(input logic [INS_W-1:0] x, input logic [REG_W-1:0] r);
    return (fv(x, 0) && fld(x, 0) == r) || (fv(x, 1) && fld(x, 1) == r);
  endfunction

  function automatic logic is_mem(input logic [INS_W-1:0] x);
    return |x[INS_W-1 -: 2];
  endfunction

  function automatic logic is_ld(input logic [INS_W-1:0] x);
    return x[INS_W-1 -: 2] == 2'd1;
  endfunction

  logic [INS_W-1:0] win  [SLOTS];
  logic [INS_W-1:0] nwin [SLOTS];
  logic [AGE_W-1:0] age  [SLOTS];
  logic [AGE_W-1:0] nage [SLOTS];
  logic [SLOTS-1:0] wv, nwv, rdy;
  logic [NREG-1:0]  ld_pend, nld;
  logic [CYC_W-1:0] cyc;
  logic [AGE_W-1:0] age_ctr;
  logic [CNT_W-1:0] n_iss, n_ld, n_free, take;
  logic [CNT_W-1:0] sp [ALU_LAT];
  logic [CNT_W-1:0] lp [LD_LAT];

  always_comb begin : pick
    logic ok;
    for (int i = 0; i < SLOTS; i++) begin
      ok = wv[i];
      if (fv(win[i], 0) && ld_pend[fld(win[i], 0)]) ok = 1'b0;
      if (fv(win[i], 1) && ld_pend[fld(win[i], 1)]) ok = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (wv[j]) begin
          if (fv(win[j], 2) && reads(win[i], fld(win[j], 2))) ok = 1'b0;
          if (fv(win[i], 2) && (reads(win[j], fld(win[i], 2)) ||
              (fv(win[j], 2) && fld(win[j], 2) == fld(win[i], 2)))) ok = 1'b0;
          if (is_mem(win[i]) && is_mem(win[j])) ok = 1'b0;
        end
      end
      rdy[i] = ok;
    end
  end

  assign n_iss  = CNT_W'($countones(rdy));
  assign n_free = CNT_W'(SLOTS - $countones(wv)) + n_iss;
  assign take   = (fetch_avail < n_free) ? fetch_avail : n_free;

  always_comb begin
    nld  = '0;
    n_ld = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rdy[i] && is_ld(win[i])) begin
        n_ld = n_ld + CNT_W'(1);
        if (fv(win[i], 2)) nld[fld(win[i], 2)] = 1'b1;
      end
    end
  end

  always_comb begin : refill
    int pos;
    pos = 0;
    nwv = '0;
    for (int i = 0; i < SLOTS; i++) begin
      nwin[i] = win[i];
      nage[i] = age[i];
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (wv[i] && !rdy[i] && pos < SLOTS) begin
        nwin[IDX_W'(pos)] = win[i];
        nage[IDX_W'(pos)] = age[i];
        nwv[IDX_W'(pos)]  = 1'b1;
        pos = pos + 1;
      end
    end
    for (int f = 0; f < SLOTS; f++) begin
      if (f < int'(take) && pos < SLOTS) begin
        nwin[IDX_W'(pos)] = fetch_ins[f*INS_W +: INS_W];
        nage[IDX_W'(pos)] = age_ctr + AGE_W'(f);
        nwv[IDX_W'(pos)]  = 1'b1;
        pos = pos + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wv      <= '0;
      ld_pend <= '0;
      cyc     <= '0;
      age_ctr <= '0;
      for (int k = 0; k < ALU_LAT; k++) sp[k] <= '0;
      for (int k = 0; k < LD_LAT; k++) lp[k] <= '0;
    end else begin
      wv      <= nwv;
      ld_pend <= nld;
      cyc     <= cyc + CYC_W'(1);
      age_ctr <= age_ctr + AGE_W'(take);
      sp[0]   <= n_iss - n_ld;
      lp[0]   <= n_ld;
      for (int k = 1; k < ALU_LAT; k++) sp[k] <= sp[k-1];
      for (int k = 1; k < LD_LAT; k++) lp[k] <= lp[k-1];
    end
  end

  always_ff @(posedge clk) begin
    win <= nwin;
    age <= nage;
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_age
      assign issue_age[g*AGE_W +: AGE_W] = age[g];
    end
  endgenerate

  assign fetch_take  = take;
  assign issue_vld   = rdy;
  assign issue_cycle = cyc;
  assign retire_cnt  = RET_W'(sp[ALU_LAT-1]) + RET_W'(lp[LD_LAT-1]);
endmodule

// File: rtl/ooo_issue_window_chk.sv
`timescale 1ns/1ps
module ooo_issue_window_chk #(
  parameter int SLOTS = 4,
  parameter int NREG = 32,
  parameter int CYC_W = 16,
  localparam int REG_W = $clog2(NREG),
  localparam int INS_W = 3 * REG_W + 5,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fetch_avail,
  input logic [CNT_W-1:0] fetch_take,
  input logic [SLOTS-1:0] issue_vld,
  input logic [CYC_W-1:0] issue_cycle,
  input logic [SLOTS-1:0] wv,
  input logic [INS_W-1:0] win [SLOTS]
);
  logic [SLOTS-1:0] mem_iss;
  logic [NREG-1:0]  ld_now, rd_now, ld_prev;

  always_comb begin
    mem_iss = '0;
    ld_now  = '0;
    rd_now  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (issue_vld[i]) begin
        mem_iss[i] = |win[i][INS_W-1 -: 2];
        if (win[i][INS_W-1 -: 2] == 2'd1 && win[i][2*(REG_W+1) + REG_W])
          ld_now[win[i][2*(REG_W+1) +: REG_W]] = 1'b1;
        if (win[i][REG_W]) rd_now[win[i][0 +: REG_W]] = 1'b1;
        if (win[i][(REG_W+1) + REG_W]) rd_now[win[i][(REG_W+1) +: REG_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ld_prev <= '0;
    else     ld_prev <= ld_now;
  end

  assert_first_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (issue_vld == '0 &&
      fetch_take == ((fetch_avail > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : fetch_avail)));

  assert_take_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_take <= fetch_avail && fetch_take <= CNT_W'(SLOTS));

  assert_take_refill_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_avail >= CNT_W'(SLOTS)) |-> fetch_take >= CNT_W'($countones(issue_vld)));

  assert_issue_occupied_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_vld & ~wv) == '0);

  assert_load_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_now & ld_prev) == '0);

  assert_mem_single_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_iss) <= 1);

  assert_cycle_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> issue_cycle == $past(issue_cycle) + CYC_W'(1));
endmodule

bind ooo_issue_window ooo_issue_window_chk #(.SLOTS(SLOTS), .NREG(NREG), .CYC_W(CYC_W)) u_chk (.*);

// File: tb/tb_ooo_issue_window.sv
`timescale 1ns/1ps
module tb_ooo_issue_window;
  localparam int NP = 36, NCYC = 80, IW = 20;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0]    fetch_avail, fetch_take;
  logic [4*IW-1:0] fetch_ins;
  logic [3:0]    issue_vld, retire_cnt;
  logic [31:0]   issue_age;
  logic [15:0]   issue_cycle;

  ooo_issue_window dut (
    .clk(clk), .rst(rst), .fetch_avail(fetch_avail), .fetch_ins(fetch_ins),
    .fetch_take(fetch_take), .issue_vld(issue_vld), .issue_age(issue_age),
    .issue_cycle(issue_cycle), .retire_cnt(retire_cnt)
  );

  typedef struct { int tag; int cyc; } exp_t;
  exp_t expq[$];
  int pc[NP], pd[NP], p1[NP], p2[NP];
  int exp_take[NCYC];
  int exp_ret[NCYC+8];
  int act[NP];
  int nfill = 0, ptr = 0, seen_take = 0, nchk = 0, nfail = 0, mc = 0;
  bit running = 1'b0;

  task automatic add(input int c, input int d, input int s1, input int s2);
    pc[nfill] = c; pd[nfill] = d; p1[nfill] = s1; p2[nfill] = s2;
    nfill++;
  endtask

  function automatic logic [IW-1:0] enc(input int k);
    return {pc[k][1:0], pd[k] >= 0, pd[k][4:0], p1[k] >= 0, p1[k][4:0], p2[k] >= 0, p2[k][4:0]};
  endfunction

  function automatic bit rd(input int k, input int r);
    return (p1[k] == r) || (p2[k] == r);
  endfunction

  function automatic bit blocks(input int o, input int k);
    if (pd[o] >= 0 && rd(k, pd[o])) return 1'b1;
    if (pd[k] >= 0 && (rd(o, pd[k]) || pd[o] == pd[k])) return 1'b1;
    if (pc[o] != 0 && pc[k] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input int a, input int e);
    nchk++;
    if (a != e) begin
      nfail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, a, e);
    end
  endtask

  task automatic push_expected();
    int w[$], keep[$], iss[$];
    int lrdy[32];
    int rp, fr, tk, k;
    bit ok;
    rp = 0;
    foreach (lrdy[r]) lrdy[r] = 0;
    foreach (exp_ret[r]) exp_ret[r] = 0;
    for (int c = 0; c < NCYC; c++) begin
      iss.delete(); keep.delete();
      for (int p = 0; p < w.size(); p++) begin
        k = w[p];
        ok = 1'b1;
        if (p1[k] >= 0 && c < lrdy[p1[k]]) ok = 1'b0;
        if (p2[k] >= 0 && c < lrdy[p2[k]]) ok = 1'b0;
        for (int q = 0; q < p; q++) if (blocks(w[q], k)) ok = 1'b0;
        if (ok) iss.push_back(k); else keep.push_back(k);
      end
      foreach (iss[i]) begin
        expq.push_back('{iss[i], c});
        exp_ret[c + ((pc[iss[i]] == 1) ? 5 : 4)]++;
        if (pc[iss[i]] == 1 && pd[iss[i]] >= 0) lrdy[pd[iss[i]]] = c + 2;
      end
      fr = 4 - w.size() + iss.size();
      tk = (fr < NP - rp) ? fr : NP - rp;
      exp_take[c] = tk;
      w = keep;
      for (int t = 0; t < tk; t++) begin
        w.push_back(rp);
        rp++;
      end
    end
  endtask

  task automatic drive_fetch();
    int av;
    av = (NP - ptr < 4) ? NP - ptr : 4;
    fetch_avail = 3'(av);
    for (int f = 0; f < 4; f++)
      fetch_ins[f*IW +: IW] = (f < av) ? enc(ptr + f) : '0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        #1;
        seen_take = int'(fetch_take);
        chk("R2", $sformatf("cycle %0d fetch_take", mc), seen_take, exp_take[mc]);
        chk("R9", $sformatf("cycle %0d retire_cnt", mc), int'(retire_cnt), exp_ret[mc]);
        if (mc == 0) begin
          chk("R1", "first cycle fetch_take", seen_take, 4);
          chk("R1", "first cycle issue_vld", int'(issue_vld), 0);
        end
        for (int s = 0; s < 4; s++) begin
          if (issue_vld[s]) begin
            if (expq.size() == 0) chk("R8", "unexpected issue", s, -1);
            else begin
              exp_t e;
              int tg;
              e = expq.pop_front();
              tg = int'(issue_age[s*8 +: 8]);
              chk("R8", $sformatf("slot %0d age tag", s), tg, e.tag & 255);
              chk("R8", $sformatf("tag %0d issue_cycle", e.tag), int'(issue_cycle), e.cyc);
              if (tg < NP) act[tg] = mc;
            end
          end
        end
        mc++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL R8 watchdog expired actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    add(0, 1, 10, 11); add(0, 2, 10, 11); add(0, 3, 12, -1); add(0, 4, 12, -1);
    add(0, 5, 1, -1);  add(0, 6, 5, -1);  add(1, 7, 10, -1); add(0, 8, 7, -1);
    add(0, 9, 13, -1); add(0, 13, 12, -1); add(0, 14, 12, -1); add(0, 14, 11, -1);
    add(1, 15, 10, -1); add(2, -1, 1, 2); add(1, 16, 11, -1);
    add(0, 2, -1, -1); add(0, 2, 2, -1); add(0, 3, 2, -1); add(0, 4, -1, -1); add(0, 4, 4, -1);
    for (int it = 0; it < 2; it++) begin
      add(1, 5, 2, -1); add(0, 5, 5, -1); add(0, 5, 4, 5); add(1, 6, 5, -1);
      add(0, 6, 6, -1); add(2, -1, 6, 5); add(0, 2, 2, -1); add(0, -1, 2, 3);
    end
    foreach (act[k]) act[k] = -1;
    push_expected();

    fetch_avail = '0;
    fetch_ins = '0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R1", "reset issue_vld", int'(issue_vld), 0);
      chk("R1", "reset retire_cnt", int'(retire_cnt), 0);
    end
    @(posedge clk);
    #1;
    rst = 1'b0;
    drive_fetch();
    running = 1'b1;
    repeat (NCYC) begin
      @(posedge clk);
      #1;
      ptr += seen_take;
      drive_fetch();
    end
    running = 1'b0;

    chk("R8", "expected issues left over", expq.size(), 0);
    for (int k = 0; k < 4; k++) chk("R10", $sformatf("independent i%0d issue cycle", k), act[k], 1);
    chk("R3", "independent load issue cycle", act[6], 2);
    chk("R3", "load overtakes blocked older", int'(act[6] < act[5]), 1);
    chk("R4", "arith consumer cycle", act[5], act[4] + 1);
    chk("R5", "load consumer cycle", act[7], act[6] + 2);
    chk("R6", "write-after-read cycle", act[9], act[8] + 1);
    chk("R6", "write-after-write cycle", act[11], act[10] + 1);
    chk("R7", "store after older load", int'(act[13] > act[12]), 1);
    chk("R7", "load after older store", int'(act[14] > act[13]), 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule